// File: doc/BRIEF.md
# SDRAM Burst-Read Cycle Sequencer

This block drives one burst read with automatic precharge from a synchronous DRAM, from the side of a processor bus controller. A request brings an address and an area select that picks one of two chip-select regions. It also says whether the data bus is 16 or 32 bits wide, and whether the beats should wrap around the missed word (cache fill) or run upward from the start of the 16-byte block (DMA). The block then steps through its phases one after another: row activate, an optional extra cycle for the row-to-column delay, read-with-precharge, CAS-latency wait cycles, the data beats, and a precharge wait.

Configuration inputs set the row-to-column delay, a separate CAS latency for each area, and the precharge time. The CAS latency can be up to four cycles, which allows latches in the data path. The precharge wait gets shorter when the CAS latency is above one, and it can then be zero. Every setting is captured when the request is accepted. The caller sees busy for the whole sequence and a one-cycle done pulse after it ends.

Top module: `sdram_burst_rd_seq`

## Requirements
- R1: After reset, cmd is NOP (2'b00) and cap_stb, bus_start, busy and done are all low.
- R2: A request seen with busy low is accepted at that clock edge. The next cycle shows cmd ACTV (2'b01), with busy high from that cycle on.
- R3: With cfg_rcd low, READA (2'b10) follows ACTV in the next cycle. With cfg_rcd high, one NOP cycle sits between ACTV and READA.
- R4: The first data beat comes CL cycles after the READA cycle, with NOP in the cycles between. CL is taken from cfg_cl_a0 when req_area is 0 and from cfg_cl_a1 when it is 1, and each code is mapped 00=1, 01=2, 10=3, 11=4.
- R5: A burst has 4 back-to-back beats when req_wide is 1 (32-bit) and 8 when it is 0 (16-bit). cap_stb and bus_start are both high in every beat and low at all other times, and cmd is NOP during beats.
- R6: mem_addr bits above bit 3 always equal those of the accepted address. In each beat, bits 3..0 advance by 4 (32-bit) or 2 (16-bit) modulo 16, and bits below the step size are zero.
- R7: When req_wrap is 1, the first beat's offset is the request's offset aligned to the bus width. When req_wrap is 0, it is 0.
- R8: After the last beat, NOP is issued for a precharge wait. With CL 1, the wait is 2 cycles if cfg_trp is 1 and 1 cycle if it is 0. With CL 2 or more, it is 1 cycle if cfg_trp is 1 and 0 cycles if it is 0.
- R9: done is high for exactly one cycle, the cycle after the last precharge-wait cycle (or after the last beat when the wait is zero). busy is low in that cycle.
- R10: Requests presented while busy is high are ignored. The sequence, its addresses and its timing do not change, and no new sequence starts after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken when busy is low |
| req_addr | input | AW | Byte address of the access |
| req_area | input | 1 | Chip-select area select (0 or 1) |
| req_wide | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| req_wrap | input | 1 | 1 = start at missed word and wrap, 0 = ascending from block start |
| cfg_rcd | input | 1 | Row-to-column delay: 0 = 1 cycle, 1 = 2 cycles |
| cfg_cl_a0 | input | 2 | CAS latency code for area 0 |
| cfg_cl_a1 | input | 2 | CAS latency code for area 1 |
| cfg_trp | input | 1 | Precharge setting: 0 = 1 cycle, 1 = 2 cycles |
| cmd | output | 2 | DRAM command: 00 NOP, 01 ACTV, 10 READA |
| mem_addr | output | AW | Address presented to the DRAM |
| cap_stb | output | 1 | Data capture strobe, high in each beat |
| bus_start | output | 1 | Bus-start strobe, high in each beat |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Faults in the phase counter or the latched settings show up as cmd timing errors. READA or the first beat moves by one cycle, and a burst of the wrong length changes when done fires. All of this appears within about twenty cycles of the request. If the beat offset register is wrong, mem_addr is wrong in the first beat where the two differ. If the wrap start logic is wrong, beat one already shows it. Stray activity after done, such as a request that should have been dropped, shows as an ACTV in the cycle after the done pulse.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_ACTV  = 2'b01,
        CMD_READA = 2'b10
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_ACT  = 3'd1,
        S_RCDW = 3'd2,
        S_RDA  = 3'd3,
        S_CASW = 3'd4,
        S_BEAT = 3'd5,
        S_PRE  = 3'd6
    } seq_e;
endpackage

// File: rtl/sbr_timing.sv
module sbr_timing #(
    parameter int BLOCK_BYTES = 16,
    parameter int CW          = 4
) (
    input  logic [1:0]    cl_code,
    input  logic          trp_long,
    input  logic          wide,
    output logic [2:0]    cl_cyc,
    output logic [1:0]    tap_cyc,
    output logic [CW-1:0] beats
);
    localparam int BEATS_32 = BLOCK_BYTES / 4;
    localparam int BEATS_16 = BLOCK_BYTES / 2;

    always_comb begin
        cl_cyc = {1'b0, cl_code} + 3'd1;
        // precharge wait is one cycle shorter once latency exceeds one
        if (cl_code == 2'b00) tap_cyc = trp_long ? 2'd2 : 2'd1;
        else                  tap_cyc = trp_long ? 2'd1 : 2'd0;
        beats = wide ? CW'(BEATS_32) : CW'(BEATS_16);
    end
endmodule

// File: rtl/sbr_offset.sv
module sbr_offset #(
    parameter int OW = 4
) (
    input  logic [OW-1:0] addr_lo,
    input  logic          req_wide,
    input  logic          req_wrap,
    input  logic [OW-1:0] cur,
    input  logic          cur_wide,
    output logic [OW-1:0] start,
    output logic [OW-1:0] next
);
    // start offset: keep bits at or above the bus step only for wrap mode
    for (genvar b = 0; b < OW; b++) begin : g_start
        if (b >= 2) begin : g_hi
            assign start[b] = req_wrap & addr_lo[b];
        end else if (b == 1) begin : g_mid
            assign start[b] = req_wrap & addr_lo[b] & ~req_wide;
        end else begin : g_lo
            assign start[b] = 1'b0;
        end
    end

    assign next = cur + (cur_wide ? OW'(4) : OW'(2));
endmodule

// File: rtl/sdram_burst_rd_seq.sv
module sdram_burst_rd_seq #(
    parameter int AW          = 24,
    parameter int BLOCK_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_area,
    input  logic          req_wide,
    input  logic          req_wrap,
    input  logic          cfg_rcd,
    input  logic [1:0]    cfg_cl_a0,
    input  logic [1:0]    cfg_cl_a1,
    input  logic          cfg_trp,
    output logic [1:0]    cmd,
    output logic [AW-1:0] mem_addr,
    output logic          cap_stb,
    output logic          bus_start,
    output logic          busy,
    output logic          done
);
    import sbr_pkg::*;

    localparam int OW = $clog2(BLOCK_BYTES);
    localparam int CW = $clog2(BLOCK_BYTES / 2) + 1;

    typedef struct packed {
        seq_e             st;
        logic [CW-1:0]    cnt;
        logic [OW-1:0]    off;
        logic [AW-OW-1:0] hi;
        logic [2:0]       cl;
        logic [1:0]       tap;
        logic [CW-1:0]    beats;
        logic             rcd;
        logic             wide;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;

    logic [2:0]    cl_w;
    logic [1:0]    tap_w;
    logic [CW-1:0] beats_w;
    logic [OW-1:0] start_w, next_w;

    sbr_timing #(.BLOCK_BYTES(BLOCK_BYTES), .CW(CW)) u_timing (
        .cl_code (req_area ? cfg_cl_a1 : cfg_cl_a0),
        .trp_long(cfg_trp),
        .wide    (req_wide),
        .cl_cyc  (cl_w),
        .tap_cyc (tap_w),
        .beats   (beats_w)
    );

    sbr_offset #(.OW(OW)) u_offset (
        .addr_lo (req_addr[OW-1:0]),
        .req_wide(req_wide),
        .req_wrap(req_wrap),
        .cur     (r_q.off),
        .cur_wide(r_q.wide),
        .start   (start_w),
        .next    (next_w)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.st    = S_ACT;
                    r_d.hi    = req_addr[AW-1:OW];
                    r_d.off   = start_w;
                    r_d.cl    = cl_w;
                    r_d.tap   = tap_w;
                    r_d.beats = beats_w;
                    r_d.rcd   = cfg_rcd;
                    r_d.wide  = req_wide;
                end
            end
            S_ACT:  r_d.st = r_q.rcd ? S_RCDW : S_RDA;
            S_RCDW: r_d.st = S_RDA;
            S_RDA: begin
                if (r_q.cl > 3'd1) begin
                    r_d.st  = S_CASW;
                    r_d.cnt = CW'(r_q.cl) - CW'(2);
                end else begin
                    r_d.st  = S_BEAT;
                    r_d.cnt = r_q.beats - CW'(1);
                end
            end
            S_CASW: begin
                if (r_q.cnt == '0) begin
                    r_d.st  = S_BEAT;
                    r_d.cnt = r_q.beats - CW'(1);
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            S_BEAT: begin
                r_d.off = next_w;
                if (r_q.cnt == '0) begin
                    if (r_q.tap != 2'd0) begin
                        r_d.st  = S_PRE;
                        r_d.cnt = CW'(r_q.tap) - CW'(1);
                    end else begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            S_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = S_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (r_q.st)
            S_ACT:   cmd = CMD_ACTV;
            S_RDA:   cmd = CMD_READA;
            default: cmd = CMD_NOP;
        endcase
    end

    assign mem_addr  = {r_q.hi, r_q.off};
    assign cap_stb   = (r_q.st == S_BEAT);
    assign bus_start = (r_q.st == S_BEAT);
    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;

    // R3: no extra delay means column read directly after activate
    a_r3_reada_next: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACTV && !r_q.rcd) |=> (cmd == CMD_READA));

    // R3: extra delay inserts a NOP after activate
    a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACTV && r_q.rcd) |=> (cmd == CMD_NOP));

    // R6: offset advances by the bus step between consecutive beats
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_stb && $past(cap_stb)) |->
        (mem_addr[OW-1:0] == OW'($past(mem_addr[OW-1:0]) + (r_q.wide ? OW'(4) : OW'(2)))));

    // R9: completion pulse only directly after a busy cycle
    a_r9_done_edge: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R10: upper address bits hold while the sequence runs
    a_r10_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr[AW-1:OW]));

    // R5: data strobes only appear while busy
    a_r5_stb_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> (busy && cmd == CMD_NOP));
endmodule

// File: tb/sim_sdram_burst_rd_seq.sv
`timescale 1ns/1ps
module sim_sdram_burst_rd_seq;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_area, req_wide, req_wrap;
    logic [AW-1:0] req_addr;
    logic          cfg_rcd, cfg_trp;
    logic [1:0]    cfg_cl_a0, cfg_cl_a1;
    logic [1:0]    cmd;
    logic [AW-1:0] mem_addr;
    logic          cap_stb, bus_start, busy, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdram_burst_rd_seq #(.AW(AW), .BLOCK_BYTES(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_area(req_area), .req_wide(req_wide), .req_wrap(req_wrap),
        .cfg_rcd(cfg_rcd), .cfg_cl_a0(cfg_cl_a0), .cfg_cl_a1(cfg_cl_a1),
        .cfg_trp(cfg_trp), .cmd(cmd), .mem_addr(mem_addr), .cap_stb(cap_stb),
        .bus_start(bus_start), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] start_off(input logic [AW-1:0] a, input bit wd, input bit wr);
        if (!wr) return 4'h0;
        return wd ? {a[3:2], 2'b00} : {a[3:1], 1'b0};
    endfunction

    function automatic int tap_len(input int cl, input bit tp);
        if (cl == 1) return tp ? 2 : 1;
        return tp ? 1 : 0;
    endfunction

    task automatic run_seq(input logic [AW-1:0] a, input bit ar, input bit wd, input bit wr,
                           input bit rc, input logic [1:0] c0, input logic [1:0] c1, input bit tp);
        int cl, nb, tap, tc, td1, tend;
        logic [3:0] st;
        @(negedge clk);
        cfg_rcd = rc; cfg_cl_a0 = c0; cfg_cl_a1 = c1; cfg_trp = tp;
        req_addr = a; req_area = ar; req_wide = wd; req_wrap = wr; req_valid = 1'b1;
        cl   = int'(ar ? c1 : c0) + 1;          // R4 code mapping
        nb   = wd ? 4 : 8;                      // R5
        tap  = tap_len(cl, tp);                 // R8
        tc   = 2 + int'(rc);                    // R3
        td1  = tc + cl;                         // R4
        tend = td1 + nb + tap;                  // R9
        st   = start_off(a, wd, wr);            // R7
        for (int t = 1; t <= tend + 1; t++) begin
            int ecmd;
            bit ecap;
            string tg;
            @(negedge clk);
            ecmd = (t == 1) ? 1 : ((t == tc) ? 2 : 0);
            ecap = (t >= td1) && (t < td1 + nb);
            if (t == 1) tg = "R2";
            else if (t <= tc) tg = "R3";
            else if (t < td1) tg = "R4";
            else if (ecap) tg = "R5";
            else if (t < tend) tg = "R8";
            else tg = "R10";
            chk(cmd == 2'(ecmd), tg, cmd, ecmd);
            chk(cap_stb == ecap, "R5 cap_stb", cap_stb, ecap);
            chk(bus_start == ecap, "R5 bus_start", bus_start, ecap);
            chk(busy == (t < tend), "R9 busy", busy, (t < tend));
            chk(done == (t == tend), "R9 done", done, (t == tend));
            if (t == 1 || ecap)
                chk(mem_addr[AW-1:4] == a[AW-1:4], "R6 upper", mem_addr[AW-1:4], a[AW-1:4]);
            if (ecap) begin
                logic [3:0] eo;
                eo = 4'(int'(st) + (t - td1) * (wd ? 4 : 2));
                chk(mem_addr[3:0] == eo, (t == td1) ? "R7 first offset" : "R6 offset",
                    mem_addr[3:0], eo);
            end
            // R10: noise on the request lines while busy
            if (t < tend) begin
                req_valid = 1'($urandom % 2);
                req_addr  = AW'($urandom);
                req_area  = 1'($urandom % 2);
                req_wide  = 1'($urandom % 2);
                req_wrap  = 1'($urandom % 2);
            end else begin
                req_valid = 1'b0;
            end
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_area = 1'b0;
        req_wide = 1'b1; req_wrap = 1'b0; cfg_rcd = 1'b0; cfg_trp = 1'b0;
        cfg_cl_a0 = 2'b00; cfg_cl_a1 = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cmd == 2'b00, "R1 cmd", cmd, 0);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(!cap_stb && !bus_start, "R1 strobes", {cap_stb, bus_start}, 0);

        // directed corners
        run_seq(24'h12345A, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b11, 1'b0); // CL1, tap1
        run_seq(24'h12345A, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 2'b11, 1'b1); // CL1, tap2
        run_seq(24'hABCDEE, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 2'b11, 1'b0); // CL4, tap0, 16-bit wrap
        run_seq(24'hABCDEE, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 2'b01, 1'b1); // ascending, CL2
        run_seq(24'h00000C, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 2'b00, 1'b0); // DMA from 0
        run_seq(24'hFFFFF6, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 2'b00, 1'b1); // CL3 narrow wrap

        for (int i = 0; i < 60; i++) begin
            run_seq(AW'($urandom), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
                    1'($urandom % 2), 2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule